// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Operand-Inversion Control

This block pairs a 32-bit integer arithmetic and logic unit with the small decoder that drives it. The main control of a processor supplies a 2-bit operation class, and the instruction's 6-bit function field is also fed in. From these two inputs the decoder builds a 4-bit control word. The word has two operand-inversion bits and a 2-bit output select. The arithmetic unit then forms the result from that word.

Subtraction comes from inverting the second operand and feeding a carry-in of one. NOR comes from inverting both operands and taking their AND. Signed set-less-than has its own output select. That select reads the sign of the difference, corrected for signed overflow.

The result, a zero flag, a signed-overflow flag, an invalid-operation flag and the control word itself are all registered. Each therefore appears one clock after its inputs are applied. Load/store address arithmetic uses the fixed-add class. Equality branches use the fixed-subtract class and the zero flag.

Top module: `alu32_unit`

## Requirements
- R1: The control word on `ctl_o` is {bit 3 invert A, bit 2 invert B, bits 1:0 select}. The select codes are 00 AND, 01 OR, 10 sum and 11 less-than. Operation class 00 yields 0010 (add), and class 01 yields 0110 (subtract).
- R2: Under operation class 10, the function field decodes as follows: 0x20 gives 0010, 0x22 gives 0110, 0x24 gives 0000, 0x25 gives 0001, 0x2A gives 0111 and 0x27 gives 1100.
- R3: Add returns A+B modulo 2^32. Subtract returns A + ~B + 1 modulo 2^32, which equals A−B.
- R4: AND and OR return the bitwise AND and OR of A and B. NOR (1100) returns ~(A|B).
- R5: Less-than returns 1 in bit 0 when A is below B as signed two's-complement numbers, and 0 otherwise. This holds even when A−B overflows. Bits 31:1 are always 0.
- R6: `zero_o` is 1 exactly when `res_o` is all zeros.
- R7: `ovf_o` is 1 only for the add and subtract control words. It is set when the two adder operands (after inversion) share a sign and the sum's sign differs from it.
- R8: Operation class 11, or any function code not listed in R2 under class 10, sets `bad_op_o` to 1. In that case the control word is 0000, the result is 0, `ovf_o` is 0 and `zero_o` is 1.
- R9: All outputs are registered, so the outputs for an input set are visible one clock after it is applied. An active-low asynchronous reset gives result 0, zero 1, overflow 0, invalid 0 and control word 0000.
- R10: Under operation classes 00 and 01, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 2 | Operation class from main control |
| func | input | 6 | Instruction function field |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| res_o | output | 32 | Registered result |
| zero_o | output | 1 | Result-is-zero flag |
| ovf_o | output | 1 | Signed overflow flag (add/subtract only) |
| bad_op_o | output | 1 | Invalid operation flag |
| ctl_o | output | 4 | Registered control word |

## Verification
Every output of this block — result, zero, overflow, invalid flag and control word — passes through exactly one register. Each is therefore due at the first rising edge after the operands and class are applied. The bench drives each input set on a falling edge and compares all five outputs on the next falling edge, half a period after that register has loaded. The reset checks are sampled on a falling edge while reset is still low, so the asynchronous clear is seen without any intervening capture.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef struct packed {
        logic inv_a;
        logic inv_b;
        sel_e sel;
    } ctl_t;

    localparam logic [1:0] CLS_ADD  = 2'b00;
    localparam logic [1:0] CLS_SUB  = 2'b01;
    localparam logic [1:0] CLS_FUNC = 2'b10;

    localparam int FUNC_W = 6;
    localparam logic [FUNC_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FUNC_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
    localparam logic [FUNC_W-1:0] FN_NOR  = 6'h27;
    localparam logic [FUNC_W-1:0] FN_LESS = 6'h2A;

endpackage

// File: rtl/alu32_decode.sv
module alu32_decode
    import alu32_pkg::*;
(
    input  logic [1:0]        cls,
    input  logic [FUNC_W-1:0] func,
    output ctl_t              ctl,
    output logic              bad
);

    always_comb begin
        ctl = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_AND};
        bad = 1'b0;
        case (cls)
            CLS_ADD: ctl = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_SUM};
            CLS_SUB: ctl = '{inv_a: 1'b0, inv_b: 1'b1, sel: SEL_SUM};
            CLS_FUNC: begin
                case (func)
                    FN_ADD:  ctl = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_SUM};
                    FN_SUB:  ctl = '{inv_a: 1'b0, inv_b: 1'b1, sel: SEL_SUM};
                    FN_AND:  ctl = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_AND};
                    FN_OR:   ctl = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_OR};
                    FN_NOR:  ctl = '{inv_a: 1'b1, inv_b: 1'b1, sel: SEL_AND};
                    FN_LESS: ctl = '{inv_a: 1'b0, inv_b: 1'b1, sel: SEL_LESS};
                    default: bad = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  ctl_t         ctl,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] sum;
    logic         ovf_raw;
    logic         less;

    assign a_eff = ctl.inv_a ? ~a : a;
    assign b_eff = ctl.inv_b ? ~b : b;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_v[i] = a_eff[i] & b_eff[i];
        assign or_v[i]  = a_eff[i] | b_eff[i];
    end

    assign sum     = a_eff + b_eff + {{(W-1){1'b0}}, ctl.inv_b};
    assign ovf_raw = (a_eff[MSB] == b_eff[MSB]) && (sum[MSB] != a_eff[MSB]);
    assign less    = sum[MSB] ^ ovf_raw;

    always_comb begin
        case (ctl.sel)
            SEL_AND:  res = and_v;
            SEL_OR:   res = or_v;
            SEL_SUM:  res = sum;
            default:  res = {{(W-1){1'b0}}, less};
        endcase
        ovf = (ctl.sel == SEL_SUM) && ovf_raw;
    end

endmodule

// File: rtl/alu32_unit.sv
module alu32_unit
    import alu32_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_class,
    input  logic [FUNC_W-1:0] func,
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    output logic [W-1:0]      res_o,
    output logic              zero_o,
    output logic              ovf_o,
    output logic              bad_op_o,
    output logic [3:0]        ctl_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        logic         bad;
        ctl_t         ctl;
    } out_t;

    ctl_t         ctl_dec;
    logic         bad_dec;
    logic [W-1:0] res_core;
    logic         ovf_core;
    out_t         st_d;
    out_t         st_q;

    alu32_decode u_decode (
        .cls  (op_class),
        .func (func),
        .ctl  (ctl_dec),
        .bad  (bad_dec)
    );

    alu32_core #(.W(W)) u_core (
        .ctl (ctl_dec),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (res_core),
        .ovf (ovf_core)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ctl = ctl_dec;
        st_d.bad = bad_dec;
        st_d.res = bad_dec ? '0 : res_core;
        st_d.ovf = bad_dec ? 1'b0 : ovf_core;
        st_d.zero = (st_d.res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.zero <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o    = st_q.res;
    assign zero_o   = st_q.zero;
    assign ovf_o    = st_q.ovf;
    assign bad_op_o = st_q.bad;
    assign ctl_o    = st_q.ctl;

    assert_fixed_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == CLS_ADD) |=> (ctl_o == 4'b0010));

    assert_fixed_sub_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == CLS_SUB) |=> (ctl_o == 4'b0110));

    assert_less_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o[1:0] == 2'b11) |-> (res_o[W-1:1] == '0));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (res_o == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (ctl_o[1:0] == 2'b10 && !ctl_o[3]));

    assert_invalid_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_o |-> (res_o == '0 && !ovf_o && ctl_o == 4'b0000));

    assert_reserved_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11) |=> bad_op_o);

endmodule

// File: tb/alu32_unit_bench.sv
module alu32_unit_bench;

    localparam int NV = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_class = '0;
    logic [5:0]  func = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] res_o;
    logic        zero_o;
    logic        ovf_o;
    logic        bad_op_o;
    logic [3:0]  ctl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    alu32_unit u_alu32_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_class (op_class),
        .func     (func),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .res_o    (res_o),
        .zero_o   (zero_o),
        .ovf_o    (ovf_o),
        .bad_op_o (bad_op_o),
        .ctl_o    (ctl_o)
    );

    // {class, func, a, b, expected res, zero, ovf, bad, ctl}
    localparam logic [110:0] VEC [NV] = '{
        {2'b00, 6'h3F, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 1'b0, 1'b0, 1'b0, 4'h2},
        {2'b01, 6'h24, 32'h0000_0009, 32'h0000_0009, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h6},
        {2'b01, 6'h00, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 4'h6},
        {2'b10, 6'h20, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 4'h2},
        {2'b10, 6'h22, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 4'h6},
        {2'b10, 6'h24, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F, 1'b0, 1'b0, 1'b0, 4'h0},
        {2'b10, 6'h25, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F, 1'b0, 1'b0, 1'b0, 4'h1},
        {2'b10, 6'h27, 32'hF0F0_F0F0, 32'h0F0F_0F00, 32'h0000_000F, 1'b0, 1'b0, 1'b0, 4'hC},
        {2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'h7},
        {2'b10, 6'h2A, 32'h0000_0005, 32'h0000_0003, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h7},
        {2'b10, 6'h2A, 32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'h7},
        {2'b10, 6'h2A, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h7},
        {2'b11, 6'h20, 32'h1234_5678, 32'h1111_1111, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 4'h0},
        {2'b10, 6'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 4'h0},
        {2'b10, 6'h20, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'h2},
        {2'b10, 6'h27, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 4'hC},
        {2'b00, 6'h22, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'h2}
    };

    function automatic string vtag(int i);
        case (i)
            0:       return "R1/R10 fixed add";
            1, 2:    return "R1/R6 fixed sub";
            3:       return "R2/R3/R7 add overflow";
            4:       return "R2/R3/R7 sub overflow";
            5, 6:    return "R2/R4 and/or";
            7, 15:   return "R2/R4 nor";
            8, 9:    return "R5 less basic";
            10, 11:  return "R5 less with overflow";
            12:      return "R8 reserved class";
            13:      return "R8 unlisted func";
            14:      return "R3/R6 wrap to zero";
            default: return "R10 func ignored, R7";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] er, logic ez, logic eo,
                         logic eb, logic [3:0] ec);
        n_chk++;
        if (res_o !== er || zero_o !== ez || ovf_o !== eo ||
            bad_op_o !== eb || ctl_o !== ec) begin
            n_bad++;
            $display("FAIL %s: got res=%h z=%b o=%b bad=%b ctl=%h, want res=%h z=%b o=%b bad=%b ctl=%h",
                     tag, res_o, zero_o, ovf_o, bad_op_o, ctl_o, er, ez, eo, eb, ec);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset state", 32'h0, 1'b1, 1'b0, 1'b0, 4'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_class = VEC[i][110:109];
            func     = VEC[i][108:103];
            opnd_a   = VEC[i][102:71];
            opnd_b   = VEC[i][70:39];
            @(negedge clk);
            check(vtag(i), VEC[i][38:7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
        end
        // R9: one-cycle latency, then asynchronous clear mid-run
        op_class = 2'b10; func = 6'h25;
        opnd_a = 32'h0000_00A0; opnd_b = 32'h0000_000B;
        @(negedge clk);
        check("R9 latency one clock", 32'h0000_00AB, 1'b0, 1'b0, 1'b0, 4'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 clear under reset", 32'h0, 1'b1, 1'b0, 1'b0, 4'h0);
        rst_n = 1'b1;
        // R10: sub class with a nor code in func still subtracts
        op_class = 2'b01; func = 6'h27;
        opnd_a = 32'h0000_0010; opnd_b = 32'h0000_0001;
        @(negedge clk);
        check("R10 func ignored under sub class", 32'h0000_000F, 1'b0, 1'b0, 1'b0, 4'h6);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule